// File: doc/BRIEF.md
# Pipelined Synchronous SRAM With Zero Bus Turnaround

This block is a synchronous single-clock SRAM whose data bus can switch between reads and writes on every cycle with no idle cycle between them. Every command, address, byte-lane enable and chip-select input is captured on the rising clock edge. A read presents its word two enabled edges after its address. A write takes its address and lane enables on one edge and its data two enabled edges later. Because both directions have the same latency, the data bus carries one transfer in every cycle.

Writes wait in a two-stage queue until their data arrives. A read that reaches an address whose write data has not yet been stored still returns the newest bytes, because the pending data is merged with the array contents lane by lane. A load command sets the cycle type and the base address. An advance command keeps the current cycle type and steps a two-bit burst counter, in linear or interleaved order. A clock-enable input freezes the whole pipeline. Write data and read data use separate ports, and an output-enable input forces the read port to zero.

Top module: `pipe_sram`

## Requirements
- R1: A read loaded at enabled edge N puts the word on `rdata` with `rdata_vld` high after enabled edge N+2.
- R2: The lane enables `lane_wen_n` are sampled with the address. The data on `wdata` is sampled at enabled edge N+2. Bit i of `lane_wen_n`, when low, writes bits 8i+7..8i and leaves the other lanes unchanged.
- R3: A load cycle (`new_cmd_n` low) selects the block only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Any other combination is a deselect, and no read data is produced for it.
- R4: With `new_cmd_n` high, the cycle type of the last load (read, write or deselect) continues at the next burst address. The command and select inputs are ignored.
- R5: The burst address keeps the upper address bits of the load address. Its two low bits are (base + k) mod 4 when `lin_order` is 1 and base XOR k when it is 0, where k counts advances since the load. The sequence wraps after four words.
- R6: While `clk_en_n` is high, rising edges have no effect: `rdata`, `rdata_vld`, pending writes and the burst state all hold.
- R7: After an enabled edge on which no read completes, `rdata_vld` is low and `rdata` is zero. Writes already in the pipeline still complete.
- R8: `drive_en_n` high forces `rdata` to zero. It does not change `rdata_vld` or the pipeline.
- R9: Any mix of reads and writes runs at one operation per enabled cycle. A read always returns the data of every write loaded before it, including writes whose data arrives one cycle before the read's data is returned.
- R10: Synchronous reset clears `rdata` and `rdata_vld`, makes the pipeline idle and discards pending writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| new_cmd_n | input | 1 | Low loads a new command, high advances the burst |
| is_read | input | 1 | 1 read, 0 write; sampled on load cycles |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| lane_wen_n | input | NB | Active-low byte-lane write enables, one per lane |
| addr | input | AW | Word address, sampled on load cycles |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata | input | NB*8 | Write data, two enabled edges after the address |
| drive_en_n | input | 1 | Active-low output enable for `rdata` |
| rdata | output | NB*8 | Registered read data |
| rdata_vld | output | 1 | High when `rdata` carries a completed read |

## Verification
The bench aims at a read that immediately follows a partial write to the same address. If the pending-write forwarding were missing, or merged the wrong lanes, the read would return stale array bytes. Burst sequences in both orders and past the wrap point catch a counter that carries into the upper address bits or uses the wrong order. Stalls placed inside write-to-read hand-offs catch a pipeline stage that keeps moving while frozen, which shifts the write data by one cycle and corrupts later reads. Deselect loads followed by advances check that no phantom read is produced and that a deselect persists through an advance.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits of burst step k from a base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] k,
                                           input logic       lin);
    return lin ? (base + k) : (base ^ k);
  endfunction
endpackage

// File: rtl/pipe_sram_ctl.sv
module pipe_sram_ctl
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          new_cmd_n,
  input  logic          is_read,
  input  logic          sel,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] lane_wen_n,
  input  logic          lin_order,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NB-1:0] s2_be
);
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nx;
  logic [NB-1:0] s1_be;

  assign cnt_nx = cnt + 2'd1;

  // Stage 1: command decode and burst address generation.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      base    <= '0;
      cnt     <= '0;
    end else if (en) begin
      s1_be <= ~lane_wen_n;
      if (!new_cmd_n) begin
        s1_op   <= sel ? (is_read ? OP_RD : OP_WR) : OP_IDLE;
        base    <= addr;
        cnt     <= '0;
        s1_addr <= addr;
      end else begin
        cnt     <= cnt_nx;
        s1_addr <= {base[AW-1:2], burst_low(base[1:0], cnt_nx, lin_order)};
      end
    end
  end

  // Stage 2: write registry holding the op whose data arrives next edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (en && !new_cmd_n && !sel) |=> (s1_op == OP_IDLE)); // R3
  AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (rst)
    (en && new_cmd_n) |=> (s1_op == $past(s1_op))); // R4
  AST_BURST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (en && new_cmd_n) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]))); // R5
endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [NB-1:0]    be,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  // One memory per lane so each maps to a block RAM with read-first behaviour.
  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[l]) mem[waddr] <= wdata[l*LW +: LW];
        rdata[l*LW +: LW] <= mem[raddr];
      end
    end
  end
endmodule

// File: rtl/pipe_sram_out.sv
module pipe_sram_out
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NB-1:0]    s2_be,
  input  logic [NB*LW-1:0] wdata,
  input  logic [NB*LW-1:0] arr_rdata,
  input  logic             drive_en_n,
  output logic [NB*LW-1:0] rdata,
  output logic             rdata_vld
);
  localparam int DW = NB * LW;

  logic          fwd_hit;
  logic [NB-1:0] fwd_be;
  logic [DW-1:0] fwd_data;
  logic [DW-1:0] merged;
  logic [DW-1:0] q_r;
  logic          vld_r;

  // Capture the write whose data lands while the read is sampling the array.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_be   <= '0;
      fwd_data <= '0;
    end else if (en) begin
      fwd_hit  <= (s1_op == OP_RD) && (s2_op == OP_WR) && (s1_addr == s2_addr);
      fwd_be   <= s2_be;
      fwd_data <= wdata;
    end
  end

  for (genvar l = 0; l < NB; l++) begin : g_merge
    assign merged[l*LW +: LW] = (fwd_hit && fwd_be[l]) ? fwd_data[l*LW +: LW]
                                                        : arr_rdata[l*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      vld_r <= 1'b0;
    end else if (en) begin
      vld_r <= (s2_op == OP_RD);
      q_r   <= (s2_op == OP_RD) ? merged : '0;
    end
  end

  assign rdata     = drive_en_n ? '0 : q_r;
  assign rdata_vld = vld_r;

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q_r) && $stable(vld_r))); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !vld_r |-> (q_r == '0)); // R7
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             new_cmd_n,
  input  logic             is_read,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic [NB-1:0]    lane_wen_n,
  input  logic [AW-1:0]    addr,
  input  logic             lin_order,
  input  logic [NB*LW-1:0] wdata,
  input  logic             drive_en_n,
  output logic [NB*LW-1:0] rdata,
  output logic             rdata_vld
);
  localparam int DW = NB * LW;

  logic          en;
  logic          sel;
  op_e           s1_op;
  op_e           s2_op;
  logic [AW-1:0] s1_addr;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_be;
  logic [DW-1:0] arr_rdata;

  assign en  = !clk_en_n;
  assign sel = !sel_a_n && sel_b && !sel_c_n;

  pipe_sram_ctl #(.AW(AW), .NB(NB)) u_ctl (
    .clk(clk), .rst(rst), .en(en), .new_cmd_n(new_cmd_n), .is_read(is_read),
    .sel(sel), .addr(addr), .lane_wen_n(lane_wen_n), .lin_order(lin_order),
    .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_be(s2_be)
  );

  pipe_sram_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
    .clk(clk), .en(en), .we(s2_op == OP_WR), .be(s2_be), .waddr(s2_addr),
    .wdata(wdata), .raddr(s1_addr), .rdata(arr_rdata)
  );

  pipe_sram_out #(.AW(AW), .NB(NB), .LW(LW)) u_out (
    .clk(clk), .rst(rst), .en(en), .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be), .wdata(wdata),
    .arr_rdata(arr_rdata), .drive_en_n(drive_en_n), .rdata(rdata),
    .rdata_vld(rdata_vld)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rdata_vld && (u_out.q_r == '0))); // R10
endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          new_cmd_n = 1'b0;
  logic          is_read = 1'b1;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b0;
  logic          sel_c_n = 1'b1;
  logic [NB-1:0] lane_wen_n = '1;
  logic [AW-1:0] addr = '0;
  logic          lin_order = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic          drive_en_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  always #5 clk = ~clk;

  pipe_sram #(.AW(AW), .NB(NB), .LW(8)) uut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .new_cmd_n(new_cmd_n),
    .is_read(is_read), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .lane_wen_n(lane_wen_n), .addr(addr), .lin_order(lin_order),
    .wdata(wdata), .drive_en_n(drive_en_n), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  typedef struct { bit vld; logic [DW-1:0] data; string tag; } exp_t;
  typedef struct { int op; int a; logic [NB-1:0] be; } pend_t;

  exp_t          exp_q[$];
  exp_t          last_it;
  logic [DW-1:0] ref_mem [1 << AW];
  pend_t         p1, p2;
  int            m_op, m_base, m_cnt;
  int            checks = 0;
  int            fails = 0;
  bit            started = 0;
  bit            done = 0;

  // Driver: one call per clock; models the pipeline to push expectations.
  task automatic cyc(input bit stall, input bit ld, input bit sel_ok,
                     input bit rd, input int a, input logic [NB-1:0] ben,
                     input bit oe_off, input string tag);
    exp_t it;
    int na;
    logic [DW-1:0] dv;
    @(negedge clk);
    clk_en_n   = stall;
    new_cmd_n  = !ld;
    is_read    = rd;
    addr       = a[AW-1:0];
    lane_wen_n = ben;
    drive_en_n = oe_off;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    if (!sel_ok) begin
      case ($urandom % 3)
        0: sel_a_n = 1'b1;
        1: sel_b   = 1'b0;
        default: sel_c_n = 1'b1;
      endcase
    end
    if (!stall) begin
      it.tag = tag; it.vld = 0; it.data = '0;
      dv = $urandom;
      wdata = dv;
      if (p2.op == 2) begin
        for (int l = 0; l < NB; l++)
          if (p2.be[l]) ref_mem[p2.a][l*8 +: 8] = dv[l*8 +: 8];
      end else if (p2.op == 1) begin
        it.vld = 1; it.data = ref_mem[p2.a];
      end
      exp_q.push_back(it);
      if (ld) begin
        m_op = sel_ok ? (rd ? 1 : 2) : 0;
        m_base = a; m_cnt = 0; na = a;
      end else begin
        m_cnt = (m_cnt + 1) % 4;
        na = (m_base & ~3) | (lin_order ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt));
      end
      p2 = p1;
      p1.op = m_op; p1.a = na; p1.be = ~ben;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 1, 0, '1, 0, "R7");
  endtask

  // Monitor: pops one expectation per enabled edge; on stalls expects a hold.
  always @(posedge clk) begin
    bit en_s, rst_s;
    exp_t it;
    string tg;
    logic [DW-1:0] eq;
    en_s = !clk_en_n; rst_s = rst;
    #1;
    if (started && !rst_s) begin
      if (en_s) begin
        if (exp_q.size() == 0) begin
          it.vld = 0; it.data = '0; it.tag = "R1";
        end else it = exp_q.pop_front();
        last_it = it;
        tg = it.tag;
      end else begin
        it = last_it;
        tg = "R6";
      end
      if (drive_en_n) tg = "R8";
      eq = drive_en_n ? '0 : it.data;
      checks++;
      if (rdata_vld !== it.vld || rdata !== eq) begin
        fails++;
        $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                 tg, rdata_vld, rdata, it.vld, eq);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    p1 = '{0, 0, '0}; p2 = '{0, 0, '0};
    m_op = 0; m_base = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++; // R10 reset state
    if (rdata_vld !== 1'b0 || rdata !== '0) begin
      fails++;
      $display("FAIL R10: actual vld=%0b data=%h expected vld=0 data=0", rdata_vld, rdata);
    end
    started = 1;
    // Fill the array (R2 full-lane writes).
    for (int a = 0; a < (1 << AW); a++) cyc(0, 1, 1, 0, a, '0, 0, "R2");
    idle(3);
    // R1 plain reads.
    for (int a = 10; a < 14; a++) cyc(0, 1, 1, 1, a, '1, 0, "R1");
    idle(3);
    // R2 partial lanes, read back later.
    cyc(0, 1, 1, 0, 20, 4'b1010, 0, "R2");
    idle(3);
    cyc(0, 1, 1, 1, 20, '1, 0, "R2");
    idle(3);
    // R9 read immediately after a partial write to the same word.
    cyc(0, 1, 1, 0, 30, 4'b0110, 0, "R9");
    cyc(0, 1, 1, 1, 30, '1, 0, "R9");
    cyc(0, 1, 1, 0, 31, 4'b0000, 0, "R9");
    cyc(0, 1, 1, 1, 31, '1, 0, "R9");
    cyc(0, 1, 1, 0, 31, 4'b1110, 0, "R9");
    cyc(0, 1, 1, 1, 31, '1, 0, "R9");
    idle(3);
    // R3 deselect with read command, R4 advance keeps deselect.
    cyc(0, 1, 0, 1, 40, '1, 0, "R3");
    cyc(0, 0, 1, 1, 0, '1, 0, "R4");
    cyc(0, 0, 1, 1, 0, '1, 0, "R4");
    idle(3);
    // R5 linear burst write and read, then interleaved wrap.
    lin_order = 1'b1;
    cyc(0, 1, 1, 0, 8'h41, '0, 0, "R5");
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, 0, '0, 0, "R5");
    cyc(0, 1, 1, 1, 8'h42, '1, 0, "R5");
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, '1, 0, "R4");
    idle(3);
    lin_order = 1'b0;
    cyc(0, 1, 1, 0, 8'h53, '0, 0, "R5");
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, 0, '0, 0, "R5");
    cyc(0, 1, 1, 1, 8'h53, '1, 0, "R5");
    for (int k = 0; k < 6; k++) cyc(0, 0, 1, 0, 0, '1, 0, "R5");
    idle(3);
    // R6 stalls inside a write-then-read hand-off.
    cyc(0, 1, 1, 0, 60, 4'b0011, 0, "R6");
    cyc(1, 1, 1, 1, 99, '0, 0, "R6");
    cyc(0, 1, 1, 1, 60, '1, 0, "R6");
    cyc(1, 0, 0, 0, 7, '0, 0, "R6");
    cyc(1, 1, 1, 0, 7, '0, 0, "R6");
    cyc(0, 1, 1, 1, 61, '1, 0, "R6");
    cyc(1, 1, 1, 1, 61, '1, 0, "R6");
    idle(3);
    // R8 output gating while reads flow.
    cyc(0, 1, 1, 1, 12, '1, 1, "R8");
    cyc(0, 1, 1, 1, 13, '1, 1, "R8");
    cyc(0, 1, 1, 1, 14, '1, 1, "R8");
    cyc(0, 1, 1, 1, 15, '1, 0, "R8");
    idle(3);
    // R9 random mixes in both burst orders.
    for (int ph = 0; ph < 2; ph++) begin
      lin_order = (ph == 0);
      for (int i = 0; i < 3000; i++) begin
        int r, a;
        r = $urandom % 100;
        a = ($urandom % 10 < 7) ? ($urandom % 16) : ($urandom % 256);
        cyc(r < 10, r >= 30, ($urandom % 100) < 85, $urandom % 2, a,
            NB'($urandom), ($urandom % 10) == 0, "R9");
      end
      idle(4);
    end
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule